// File: doc/BRIEF.md
# Shared Functional-Unit Standby Bank with Thread Round-Robin Issue

This block sits in front of one functional unit that several hardware threads share. It holds a small pool of standby stations, which work as reservation stations. Decode places an operation into a free station together with its two source operands. An operand may still be pending. In that case it carries the tag of the result that will supply it. The station watches the result broadcast bus and captures the value when the tag matches. An operation whose operands are all present becomes ready. In each cycle the bank hands at most one ready operation to the unit. When more than one thread has ready work, the choice of thread rotates round-robin, so no thread is starved.

Decode stalls only when every station is occupied and none of them leaves in the current cycle. A station that dispatches is free again in the same cycle and can take a new operation in that cycle. One parameter selects a unit that is not pipelined, which accepts a new operation only after the previous one has finished. A second parameter selects a memory-port variant. In that variant the operations of one thread leave strictly in allocation order, and a thread that already has memory work waiting at another port is refused here.

Each station is a three-state machine. The states are FREE (empty), WAIT (holding an operation with at least one missing operand) and READY (all operands present). Its transitions are:
- alloc-ready: FREE to READY.
- alloc-wait: FREE to WAIT.
- wake: WAIT to READY, when a broadcast supplies the last missing operand.
- dispatch: READY to FREE.
- dispatch-and-refill: READY to READY or to WAIT, when a new operation enters in the dispatch cycle.

The unit gate is a two-state machine with the states IDLE and BUSY. Its transitions are:
- start: IDLE to BUSY, on a dispatch to a non-pipelined unit with latency above one.
- finish: BUSY to IDLE, when the remaining-cycle count reaches one.

Top module: `standby_bank`

## Requirements
- R1: After reset no station is occupied. `stations_full`, `issue_valid` and every bit of `mem_pending` read 0.
- R2: An operation allocated with both operands ready (`alloc_a_rdy`=1, `alloc_b_rdy`=1) appears on the issue port in the next cycle. It carries its thread, destination tag and operand values.
- R3: An operand allocated with its ready flag at 0 stays pending until a broadcast (`bcast_valid`=1) carries a matching tag. A broadcast with any other tag has no effect. The value is captured, and the operation can issue in the cycle after the matching broadcast.
- R4: A broadcast whose tag matches a pending operand in the same cycle that the operand is allocated is captured. The operation can then issue in the next cycle.
- R5: When every station is occupied and none dispatches, `stations_full`=1 and `alloc_accept`=0. A refused operation is never issued.
- R6: A station that dispatches in a cycle counts as free in that cycle. With all stations occupied and one dispatching, `stations_full`=0 and a new operation is accepted.
- R7: The issued thread is the first thread with a ready operation, searching upward from a rotation pointer and wrapping after thread NUM_THREADS-1. The pointer is 0 after reset. It moves to the thread after the granted one, and it moves only on a grant.
- R8: In the default variant, a thread's oldest ready operation issues before its younger ready ones. A younger ready operation may pass an older one that is still waiting.
- R9: In the non-pipelined variant (UNIT_PIPELINED=0, UNIT_LATENCY=L>1), two dispatches are at least L cycles apart.
- R10: In the memory variant (IS_MEMORY=1), a thread's operations issue in allocation order. A ready younger operation waits behind an older one of the same thread that is still waiting.
- R11: `mem_pending[t]`=1 while any station holds an operation of thread t. In the memory variant, an allocation of thread t is refused while `peer_mem_pending[t]`=1. In the default variant `peer_mem_pending` is ignored.
- R12: At most one operation is issued per cycle. Two operations that become ready together issue in two successive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Decode offers an operation |
| alloc_thread | input | THR_W | Thread of the offered operation |
| alloc_dst | input | TAG_W | Destination tag of the operation |
| alloc_a_rdy | input | 1 | Operand A value is present |
| alloc_a_tag | input | TAG_W | Producer tag for operand A |
| alloc_a_val | input | DATA_W | Operand A value |
| alloc_b_rdy | input | 1 | Operand B value is present |
| alloc_b_tag | input | TAG_W | Producer tag for operand B |
| alloc_b_val | input | DATA_W | Operand B value |
| peer_mem_pending | input | NUM_THREADS | Threads with memory work waiting at another port |
| alloc_accept | output | 1 | Offered operation is taken this cycle |
| stations_full | output | 1 | No station can take an operation this cycle |
| mem_pending | output | NUM_THREADS | Threads with an operation held here |
| bcast_valid | input | 1 | Result broadcast is valid |
| bcast_tag | input | TAG_W | Tag of the broadcast result |
| bcast_val | input | DATA_W | Broadcast result value |
| issue_valid | output | 1 | An operation goes to the unit |
| issue_thread | output | THR_W | Thread of the issued operation |
| issue_dst | output | TAG_W | Destination tag of the issued operation |
| issue_a | output | DATA_W | Operand A of the issued operation |
| issue_b | output | DATA_W | Operand B of the issued operation |

## Verification
The hardest situation to reach is a choice among several ready stations. Each operation becomes ready in its own cycle, so ready stations are normally drained one at a time as they appear. The bench therefore parks two operations on one common producer tag and releases them with a single broadcast. This forces a real round-robin decision, an oldest-first decision and a memory-order hold. The refill-during-dispatch case is reached in the same way: both stations are filled with parked work, and a new offer is made in the cycle the first parked operation leaves.

// File: rtl/standby_pkg.sv
`timescale 1ns/1ps
package standby_pkg;

    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READY = 2'd2
    } stn_state_e;

    typedef enum logic {
        U_IDLE = 1'b0,
        U_BUSY = 1'b1
    } unit_state_e;

endpackage

// File: rtl/standby_entry.sv
`timescale 1ns/1ps
module standby_entry
    import standby_pkg::*;
#(
    parameter int TAG_W  = 5,
    parameter int DATA_W = 16,
    parameter int THR_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [THR_W-1:0]  alloc_thread,
    input  logic [TAG_W-1:0]  alloc_dst,
    input  logic              alloc_a_rdy,
    input  logic [TAG_W-1:0]  alloc_a_tag,
    input  logic [DATA_W-1:0] alloc_a_val,
    input  logic              alloc_b_rdy,
    input  logic [TAG_W-1:0]  alloc_b_tag,
    input  logic [DATA_W-1:0] alloc_b_val,
    input  logic              bcast_valid,
    input  logic [TAG_W-1:0]  bcast_tag,
    input  logic [DATA_W-1:0] bcast_val,
    input  logic              grant,
    output logic              valid,
    output logic              ready,
    output logic [THR_W-1:0]  thread,
    output logic [TAG_W-1:0]  dst,
    output logic [DATA_W-1:0] a_val,
    output logic [DATA_W-1:0] b_val
);

    stn_state_e        state_q, state_d;
    logic              a_rdy_q, b_rdy_q;
    logic [TAG_W-1:0]  a_tag_q, b_tag_q;
    logic [DATA_W-1:0] a_val_q, b_val_q;
    logic [THR_W-1:0]  thr_q;
    logic [TAG_W-1:0]  dst_q;

    // capture at allocation time (same-cycle broadcast)
    logic a_hit_new, b_hit_new, new_ready;
    // capture while waiting
    logic a_hit_old, b_hit_old, a_now, b_now;

    always_comb begin
        a_hit_new = !alloc_a_rdy && bcast_valid && (bcast_tag == alloc_a_tag);
        b_hit_new = !alloc_b_rdy && bcast_valid && (bcast_tag == alloc_b_tag);
        new_ready = (alloc_a_rdy || a_hit_new) && (alloc_b_rdy || b_hit_new);
        a_hit_old = !a_rdy_q && bcast_valid && (bcast_tag == a_tag_q);
        b_hit_old = !b_rdy_q && bcast_valid && (bcast_tag == b_tag_q);
        a_now     = a_rdy_q || a_hit_old;
        b_now     = b_rdy_q || b_hit_old;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE: begin
                if (alloc_en) state_d = new_ready ? ST_READY : ST_WAIT;
            end
            ST_WAIT: begin
                if (a_now && b_now) state_d = ST_READY;
            end
            ST_READY: begin
                if (grant) begin
                    if (alloc_en) state_d = new_ready ? ST_READY : ST_WAIT;
                    else          state_d = ST_FREE;
                end
            end
            default: state_d = ST_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_d;
    end

    // operand and payload storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_rdy_q <= 1'b0;
            b_rdy_q <= 1'b0;
            a_tag_q <= '0;
            b_tag_q <= '0;
            a_val_q <= '0;
            b_val_q <= '0;
            thr_q   <= '0;
            dst_q   <= '0;
        end else if (alloc_en) begin
            thr_q   <= alloc_thread;
            dst_q   <= alloc_dst;
            a_tag_q <= alloc_a_tag;
            b_tag_q <= alloc_b_tag;
            a_rdy_q <= alloc_a_rdy || a_hit_new;
            b_rdy_q <= alloc_b_rdy || b_hit_new;
            a_val_q <= a_hit_new ? bcast_val : alloc_a_val;
            b_val_q <= b_hit_new ? bcast_val : alloc_b_val;
        end else if (state_q == ST_WAIT) begin
            if (a_hit_old) begin
                a_rdy_q <= 1'b1;
                a_val_q <= bcast_val;
            end
            if (b_hit_old) begin
                b_rdy_q <= 1'b1;
                b_val_q <= bcast_val;
            end
        end
    end

    // outputs
    always_comb begin
        valid  = (state_q != ST_FREE);
        ready  = (state_q == ST_READY);
        thread = thr_q;
        dst    = dst_q;
        a_val  = a_val_q;
        b_val  = b_val_q;
    end

    // a grant must only reach a station whose operands are all present
    assert_grant_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (state_q == ST_READY));

    // refill only into an empty station or one leaving this cycle
    assert_alloc_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> ((state_q == ST_FREE) || grant));

endmodule

// File: rtl/standby_rr.sv
`timescale 1ns/1ps
module standby_rr #(
    parameter int NUM_THREADS = 4,
    parameter int THR_W       = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_THREADS-1:0] req,
    input  logic                   enable,
    output logic                   grant_any,
    output logic [THR_W-1:0]       grant_thr
);

    logic [THR_W-1:0] ptr_q;
    logic             found;

    always_comb begin
        int idx;
        found     = 1'b0;
        grant_thr = '0;
        for (int off = 0; off < NUM_THREADS; off++) begin
            idx = int'(ptr_q) + off;
            if (idx >= NUM_THREADS) idx = idx - NUM_THREADS;
            if (!found && req[idx]) begin
                found     = 1'b1;
                grant_thr = THR_W'(idx);
            end
        end
        grant_any = enable && found;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (grant_any) begin
            if (grant_thr == THR_W'(NUM_THREADS - 1)) ptr_q <= '0;
            else                                      ptr_q <= grant_thr + THR_W'(1);
        end
    end

    assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_any |=> $stable(ptr_q));

    assert_grant_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        grant_any |-> req[grant_thr]);

endmodule

// File: rtl/standby_gate.sv
`timescale 1ns/1ps
module standby_gate
    import standby_pkg::*;
#(
    parameter int UNIT_PIPELINED = 1,
    parameter int UNIT_LATENCY   = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dispatch,
    output logic unit_free
);

    localparam bit BLOCKING = (UNIT_PIPELINED == 0) && (UNIT_LATENCY > 1);
    localparam int CNT_W    = $clog2(UNIT_LATENCY + 1);

    unit_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            U_IDLE: if (dispatch && BLOCKING) state_d = U_BUSY;
            U_BUSY: if (cnt_q == CNT_W'(1))   state_d = U_IDLE;
            default: state_d = U_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= U_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == U_IDLE && dispatch) cnt_q <= CNT_W'(UNIT_LATENCY - 1);
            else if (state_q == U_BUSY)        cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    always_comb unit_free = (state_q == U_IDLE);

    assert_busy_no_dispatch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == U_BUSY) |-> !dispatch);

endmodule

// File: rtl/standby_bank.sv
`timescale 1ns/1ps
module standby_bank #(
    parameter int NUM_THREADS    = 4,
    parameter int NUM_STATIONS   = 2,
    parameter int TAG_W          = 5,
    parameter int DATA_W         = 16,
    parameter int UNIT_PIPELINED = 1,
    parameter int UNIT_LATENCY   = 1,
    parameter int IS_MEMORY      = 0,
    localparam int THR_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc_valid,
    input  logic [THR_W-1:0]       alloc_thread,
    input  logic [TAG_W-1:0]       alloc_dst,
    input  logic                   alloc_a_rdy,
    input  logic [TAG_W-1:0]       alloc_a_tag,
    input  logic [DATA_W-1:0]      alloc_a_val,
    input  logic                   alloc_b_rdy,
    input  logic [TAG_W-1:0]       alloc_b_tag,
    input  logic [DATA_W-1:0]      alloc_b_val,
    input  logic [NUM_THREADS-1:0] peer_mem_pending,
    output logic                   alloc_accept,
    output logic                   stations_full,
    output logic [NUM_THREADS-1:0] mem_pending,
    input  logic                   bcast_valid,
    input  logic [TAG_W-1:0]       bcast_tag,
    input  logic [DATA_W-1:0]      bcast_val,
    output logic                   issue_valid,
    output logic [THR_W-1:0]       issue_thread,
    output logic [TAG_W-1:0]       issue_dst,
    output logic [DATA_W-1:0]      issue_a,
    output logic [DATA_W-1:0]      issue_b
);

    logic [NUM_STATIONS-1:0] stn_valid, stn_ready, eligible, grant_vec, free_slot, alloc_vec;
    logic [THR_W-1:0]        stn_thr [NUM_STATIONS];
    logic [TAG_W-1:0]        stn_dst [NUM_STATIONS];
    logic [DATA_W-1:0]       stn_a   [NUM_STATIONS];
    logic [DATA_W-1:0]       stn_b   [NUM_STATIONS];
    // older_q[j][i] = station j was allocated before station i
    logic [NUM_STATIONS-1:0] older_q [NUM_STATIONS];

    logic [NUM_THREADS-1:0]  thread_req;
    logic                    grant_any, unit_free, order_block;
    logic [THR_W-1:0]        grant_thr;

    // station array
    for (genvar i = 0; i < NUM_STATIONS; i++) begin : g_stn
        standby_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W), .THR_W(THR_W)) u_entry (
            .clk         (clk),
            .rst_n       (rst_n),
            .alloc_en    (alloc_vec[i]),
            .alloc_thread(alloc_thread),
            .alloc_dst   (alloc_dst),
            .alloc_a_rdy (alloc_a_rdy),
            .alloc_a_tag (alloc_a_tag),
            .alloc_a_val (alloc_a_val),
            .alloc_b_rdy (alloc_b_rdy),
            .alloc_b_tag (alloc_b_tag),
            .alloc_b_val (alloc_b_val),
            .bcast_valid (bcast_valid),
            .bcast_tag   (bcast_tag),
            .bcast_val   (bcast_val),
            .grant       (grant_vec[i]),
            .valid       (stn_valid[i]),
            .ready       (stn_ready[i]),
            .thread      (stn_thr[i]),
            .dst         (stn_dst[i]),
            .a_val       (stn_a[i]),
            .b_val       (stn_b[i])
        );
    end

    // per-thread ordering: oldest ready (default) or oldest held (memory)
    always_comb begin
        logic blk;
        eligible = '0;
        for (int i = 0; i < NUM_STATIONS; i++) begin
            blk = 1'b0;
            for (int j = 0; j < NUM_STATIONS; j++) begin
                if (j != i && stn_valid[j] && (stn_thr[j] == stn_thr[i]) &&
                    older_q[j][i] && ((IS_MEMORY != 0) || stn_ready[j]))
                    blk = 1'b1;
            end
            eligible[i] = stn_ready[i] && !blk;
        end
    end

    always_comb begin
        thread_req = '0;
        for (int i = 0; i < NUM_STATIONS; i++)
            if (eligible[i]) thread_req[stn_thr[i]] = 1'b1;
    end

    standby_rr #(.NUM_THREADS(NUM_THREADS), .THR_W(THR_W)) u_rr (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (thread_req),
        .enable   (unit_free),
        .grant_any(grant_any),
        .grant_thr(grant_thr)
    );

    standby_gate #(.UNIT_PIPELINED(UNIT_PIPELINED), .UNIT_LATENCY(UNIT_LATENCY)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .dispatch (grant_any),
        .unit_free(unit_free)
    );

    // grant and issue mux
    always_comb begin
        issue_thread = '0;
        issue_dst    = '0;
        issue_a      = '0;
        issue_b      = '0;
        for (int i = 0; i < NUM_STATIONS; i++) begin
            grant_vec[i] = grant_any && eligible[i] && (stn_thr[i] == grant_thr);
            if (grant_vec[i]) begin
                issue_thread = issue_thread | stn_thr[i];
                issue_dst    = issue_dst    | stn_dst[i];
                issue_a      = issue_a      | stn_a[i];
                issue_b      = issue_b      | stn_b[i];
            end
        end
        issue_valid = grant_any;
    end

    // allocation and backpressure
    always_comb begin
        logic found;
        free_slot     = ~stn_valid | grant_vec;
        stations_full = ~|free_slot;
        order_block   = (IS_MEMORY != 0) && peer_mem_pending[alloc_thread];
        alloc_accept  = alloc_valid && !stations_full && !order_block;
        alloc_vec     = '0;
        found         = 1'b0;
        for (int i = 0; i < NUM_STATIONS; i++) begin
            if (!found && free_slot[i] && alloc_accept) begin
                alloc_vec[i] = 1'b1;
                found        = 1'b1;
            end
        end
    end

    // age matrix
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_STATIONS; i++) older_q[i] <= '0;
        end else begin
            for (int k = 0; k < NUM_STATIONS; k++) begin
                if (alloc_vec[k]) begin
                    for (int i = 0; i < NUM_STATIONS; i++) begin
                        if (i != k) begin
                            older_q[i][k] <= stn_valid[i] && !grant_vec[i];
                            older_q[k][i] <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    always_comb begin
        mem_pending = '0;
        for (int i = 0; i < NUM_STATIONS; i++)
            if (stn_valid[i]) mem_pending[stn_thr[i]] = 1'b1;
    end

    assert_one_grant_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));

    assert_full_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stations_full |-> !alloc_accept);

    assert_peer_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((IS_MEMORY != 0) && alloc_valid && peer_mem_pending[alloc_thread]) |-> !alloc_accept);

    assert_issue_thread_R7: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> mem_pending[issue_thread]);

endmodule

// File: tb/standby_bank_tb.sv
`timescale 1ns/1ps
module standby_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid;
    logic [1:0]  alloc_thread;
    logic [4:0]  alloc_dst, alloc_a_tag, alloc_b_tag;
    logic        alloc_a_rdy, alloc_b_rdy;
    logic [15:0] alloc_a_val, alloc_b_val;
    logic [3:0]  peer_pend;
    logic        bcast_valid;
    logic [4:0]  bcast_tag;
    logic [15:0] bcast_val;

    logic        d_acc, d_full, d_iv;
    logic [3:0]  d_mp;
    logic [1:0]  d_thr;
    logic [4:0]  d_dst;
    logic [15:0] d_a, d_b;

    logic        v_acc, v_full, v_iv;
    logic [3:0]  v_mp;
    logic [1:0]  v_thr;
    logic [4:0]  v_dst;
    logic [15:0] v_a, v_b;

    logic        m_acc, m_full, m_iv;
    logic [3:0]  m_mp;
    logic [1:0]  m_thr;
    logic [4:0]  m_dst;
    logic [15:0] m_a, m_b;

    int n_checks = 0;
    int n_err    = 0;

    always #2 clk = ~clk;

    standby_bank u_dut (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_thread(alloc_thread),
        .alloc_dst(alloc_dst), .alloc_a_rdy(alloc_a_rdy), .alloc_a_tag(alloc_a_tag),
        .alloc_a_val(alloc_a_val), .alloc_b_rdy(alloc_b_rdy), .alloc_b_tag(alloc_b_tag),
        .alloc_b_val(alloc_b_val), .peer_mem_pending(peer_pend), .alloc_accept(d_acc),
        .stations_full(d_full), .mem_pending(d_mp), .bcast_valid(bcast_valid),
        .bcast_tag(bcast_tag), .bcast_val(bcast_val), .issue_valid(d_iv),
        .issue_thread(d_thr), .issue_dst(d_dst), .issue_a(d_a), .issue_b(d_b));

    standby_bank #(.UNIT_PIPELINED(0), .UNIT_LATENCY(4)) u_div (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_thread(alloc_thread),
        .alloc_dst(alloc_dst), .alloc_a_rdy(alloc_a_rdy), .alloc_a_tag(alloc_a_tag),
        .alloc_a_val(alloc_a_val), .alloc_b_rdy(alloc_b_rdy), .alloc_b_tag(alloc_b_tag),
        .alloc_b_val(alloc_b_val), .peer_mem_pending(4'b0000), .alloc_accept(v_acc),
        .stations_full(v_full), .mem_pending(v_mp), .bcast_valid(bcast_valid),
        .bcast_tag(bcast_tag), .bcast_val(bcast_val), .issue_valid(v_iv),
        .issue_thread(v_thr), .issue_dst(v_dst), .issue_a(v_a), .issue_b(v_b));

    standby_bank #(.IS_MEMORY(1)) u_mem (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_thread(alloc_thread),
        .alloc_dst(alloc_dst), .alloc_a_rdy(alloc_a_rdy), .alloc_a_tag(alloc_a_tag),
        .alloc_a_val(alloc_a_val), .alloc_b_rdy(alloc_b_rdy), .alloc_b_tag(alloc_b_tag),
        .alloc_b_val(alloc_b_val), .peer_mem_pending(peer_pend), .alloc_accept(m_acc),
        .stations_full(m_full), .mem_pending(m_mp), .bcast_valid(bcast_valid),
        .bcast_tag(bcast_tag), .bcast_val(bcast_val), .issue_valid(m_iv),
        .issue_thread(m_thr), .issue_dst(m_dst), .issue_a(m_a), .issue_b(m_b));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        alloc_valid = 1'b0; alloc_thread = '0; alloc_dst = '0;
        alloc_a_rdy = 1'b0; alloc_a_tag = '0; alloc_a_val = '0;
        alloc_b_rdy = 1'b0; alloc_b_tag = '0; alloc_b_val = '0;
        bcast_valid = 1'b0; bcast_tag = '0; bcast_val = '0;
        peer_pend = '0;
    endtask

    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    task automatic alloc(input int thr, input int dst, input int ar, input int at, input int av,
                         input int br, input int bt, input int bv);
        alloc_valid  = 1'b1;
        alloc_thread = 2'(thr);
        alloc_dst    = 5'(dst);
        alloc_a_rdy  = 1'(ar); alloc_a_tag = 5'(at); alloc_a_val = 16'(av);
        alloc_b_rdy  = 1'(br); alloc_b_tag = 5'(bt); alloc_b_val = 16'(bv);
    endtask

    task automatic bcast(input int tag, input int val);
        bcast_valid = 1'b1;
        bcast_tag   = 5'(tag);
        bcast_val   = 16'(val);
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        tick(); #1;
        check("R1 full", d_full, 0);
        check("R1 issue_valid", d_iv, 0);
        check("R1 mem_pending", d_mp, 0);
        check("R1 div issue_valid", v_iv, 0);
        check("R1 mem issue_valid", m_iv, 0);
    endtask

    task automatic t_basic();
        do_reset();
        tick(); alloc(1, 3, 1, 0, 10, 1, 0, 20); #1;
        check("R2 accept", d_acc, 1);
        check("R2 no same-cycle issue", d_iv, 0);
        tick(); #1;
        check("R2 issue_valid", d_iv, 1);
        check("R2 thread", d_thr, 1);
        check("R2 dst", d_dst, 3);
        check("R2 a", d_a, 10);
        check("R2 b", d_b, 20);
        tick(); #1;
        check("R2 single issue", d_iv, 0);
    endtask

    task automatic t_wakeup();
        do_reset();
        tick(); alloc(2, 4, 0, 7, 0, 1, 0, 5); #1;
        tick(); #1;
        check("R3 waiting no issue", d_iv, 0);
        tick(); bcast(9, 99); #1;
        check("R3 wrong-tag cycle", d_iv, 0);
        tick(); bcast(7, 42); #1;
        check("R3 wrong tag ignored", d_iv, 0);
        tick(); #1;
        check("R3 issue after wake", d_iv, 1);
        check("R3 captured a", d_a, 42);
        check("R3 b kept", d_b, 5);
        check("R3 dst", d_dst, 4);
    endtask

    task automatic t_bypass();
        do_reset();
        tick(); alloc(0, 6, 0, 9, 0, 1, 0, 1); bcast(9, 77); #1;
        tick(); #1;
        check("R4 issue after bypass", d_iv, 1);
        check("R4 bypass value", d_a, 77);
    endtask

    task automatic t_full();
        do_reset();
        tick(); alloc(0, 1, 0, 11, 0, 1, 0, 0); #1;
        tick(); alloc(1, 2, 0, 11, 0, 1, 0, 0); #1;
        tick(); alloc(3, 15, 1, 0, 0, 1, 0, 0); #1;
        check("R5 full", d_full, 1);
        check("R5 refused", d_acc, 0);
        tick(); bcast(11, 5); #1;
        check("R5 waiting", d_iv, 0);
        tick(); alloc(2, 9, 1, 0, 0, 1, 0, 0); #1;
        check("R6 issue first", d_iv, 1);
        check("R6 thread0", d_thr, 0);
        check("R6 not full while dispatching", d_full, 0);
        check("R6 refill accepted", d_acc, 1);
        tick(); #1;
        check("R5 second dst", d_dst, 2);
        check("R5 second valid", d_iv, 1);
        tick(); #1;
        check("R6 refilled op dst", d_dst, 9);
        check("R6 refilled op valid", d_iv, 1);
        tick(); #1;
        check("R5 refused op never issues", d_iv, 0);
    endtask

    task automatic t_rr();
        do_reset();
        tick(); alloc(2, 2, 0, 7, 0, 1, 0, 0); #1;
        tick(); alloc(0, 0, 0, 7, 0, 1, 0, 0); #1;
        tick(); bcast(7, 1); #1;
        tick(); #1;
        check("R7 pointer0 picks thread0", d_thr, 0);
        check("R12 first of pair", d_iv, 1);
        tick(); #1;
        check("R7 then thread2", d_thr, 2);
        check("R12 second of pair", d_iv, 1);
        tick(); #1;
        check("R7 drained", d_iv, 0);
        tick(); alloc(1, 1, 0, 8, 0, 1, 0, 0); #1;
        tick(); alloc(3, 3, 0, 8, 0, 1, 0, 0); #1;
        tick(); bcast(8, 1); #1;
        tick(); #1;
        check("R7 pointer3 picks thread3", d_thr, 3);
        tick(); #1;
        check("R7 wrap to thread1", d_thr, 1);
    endtask

    task automatic t_age();
        do_reset();
        tick(); alloc(1, 5, 0, 6, 0, 1, 0, 0); #1;
        tick(); alloc(1, 6, 1, 0, 0, 1, 0, 0); #1;
        tick(); alloc(1, 7, 0, 6, 0, 1, 0, 0); #1;
        check("R8 younger ready passes waiting", d_iv, 1);
        check("R8 dst", d_dst, 6);
        check("R10 mem younger held", m_iv, 0);
        check("R10 mem full", m_acc, 0);
        tick(); bcast(6, 3); #1;
        check("R8 none before wake", d_iv, 0);
        tick(); #1;
        check("R8 oldest first", d_dst, 5);
        check("R10 mem oldest first", m_dst, 5);
        check("R10 mem valid", m_iv, 1);
        tick(); #1;
        check("R8 younger next", d_dst, 7);
        check("R10 mem in order", m_dst, 6);
        check("R10 mem valid2", m_iv, 1);
        tick(); #1;
        check("R8 drained", d_iv, 0);
    endtask

    task automatic t_div();
        do_reset();
        tick(); alloc(0, 1, 1, 0, 0, 1, 0, 0); #1;
        tick(); alloc(1, 2, 1, 0, 0, 1, 0, 0); #1;
        check("R9 first dispatch", v_iv, 1);
        check("R9 first dst", v_dst, 1);
        tick(); #1;
        check("R9 busy gap1", v_iv, 0);
        check("R9 pipelined contrast", d_iv, 1);
        tick(); #1;
        check("R9 busy gap2", v_iv, 0);
        tick(); #1;
        check("R9 busy gap3", v_iv, 0);
        tick(); #1;
        check("R9 second after latency", v_iv, 1);
        check("R9 second dst", v_dst, 2);
    endtask

    task automatic t_peer();
        do_reset();
        tick(); alloc(1, 1, 0, 3, 0, 1, 0, 0); #1;
        tick(); #1;
        check("R11 mem_pending", m_mp, 4'b0010);
        tick(); peer_pend = 4'b0100; alloc(2, 2, 1, 0, 0, 1, 0, 0); #1;
        check("R11 peer refuses", m_acc, 0);
        check("R11 default ignores peer", d_acc, 1);
        tick(); #1;
        check("R11 refused no issue", m_iv, 0);
        check("R11 refused not held", m_mp, 4'b0010);
        tick(); peer_pend = 4'b0100; alloc(3, 4, 1, 0, 0, 1, 0, 0); #1;
        check("R11 other thread accepted", m_acc, 1);
        tick(); #1;
        check("R11 other thread issues", m_thr, 3);
        check("R11 other thread valid", m_iv, 1);
    endtask

    initial begin
        idle();
        t_reset();
        t_basic();
        t_wakeup();
        t_bypass();
        t_full();
        t_rr();
        t_age();
        t_div();
        t_peer();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule